// File: doc/BRIEF.md
# Pairwise First-Letter Uppercasing Byte Stream

This block sits between a host-to-device byte channel and a device-to-host byte channel, in the place a plain FIFO would normally occupy. It takes incoming characters two at a time. The first character of each pair is turned from lower case into upper case, and the second is kept as it is. Both are then handed to the reader, first one first. Feeding it `john` yields `JoHn`.

Both sides use a FIFO-style handshake. The writer sees a full flag, and a byte is taken on any clock edge where the write strobe is high and full is low. The reader sees an empty flag and read data in first-word-fall-through style: the data is valid whenever empty is low, and it is consumed by raising the read strobe. The block holds one pair at most. Once two bytes are captured it refuses writes until both have been read.

Besides an asynchronous active-low reset, which is released synchronously, the block clears itself synchronously whenever neither channel is open. A half-captured pair is lost when that happens.

Top module: `pair_upcase_stream`

## Requirements
- R1: After reset is released, and while no pair is held, `empty` is 1 and `full` is 0.
- R2: The first byte of a pair leaves as the byte minus 0x20 if it lies in 0x61..0x7A. Otherwise it leaves unchanged.
- R3: The second byte of a pair leaves unchanged, whatever its value.
- R4: After two accepted writes, `full` is 1 and `empty` is 0. The reader then sees the converted first byte, and after one read the second byte. After the second read, `empty` is 1 and `full` is 0 again.
- R5: A write strobe while `full` is 1 is ignored. The presented byte and the later read sequence are unchanged.
- R6: While `empty` is 0 and `rd_en` is 0, `rd_data` holds its value and `empty` stays 0.
- R7: A read strobe while `empty` is 1 has no effect. A pair still being captured completes normally.
- R8: When both `wr_open` and `rd_open` are 0 at a clock edge, the block clears. Any half-captured byte is discarded and is never output, and the next pair starts afresh.
- R9: With only one of `wr_open` or `rd_open` at 1, the block runs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_open | input | 1 | Write channel open; the block clears when this and `rd_open` are both 0 |
| rd_open | input | 1 | Read channel open |
| wr_en | input | 1 | Write strobe, taken when `full` is 0 |
| wr_data | input | 8 | Byte from the writer |
| full | output | 1 | Pair held, writes refused |
| rd_en | input | 1 | Read strobe, consumes `rd_data` when `empty` is 0 |
| rd_data | output | 8 | Byte presented to the reader, valid when `empty` is 0 |
| empty | output | 1 | No byte available |

## Verification
The properties assume that the write and read strobes are clean 0/1 levels held over a whole cycle. They also assume that channel-open changes arrive synchronously to the clock. Every strobe is therefore changed only on the falling edge.

The checks for ignored accesses rely on writers and readers that may violate the handshake at will. The stimulus deliberately raises the write strobe while a pair is held and raises the read strobe while empty. It also closes both channels in the middle of a pair. Random pairs cover the whole 0..255 byte range with random idle gaps, and directed vectors cover the range edges 0x60, 0x61, 0x7A and 0x7B.

// File: rtl/puc_pkg.sv
package puc_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PAIR_N  = 2;

  localparam logic [BYTE_W-1:0] LOWER_FIRST = 8'h61;
  localparam logic [BYTE_W-1:0] LOWER_LAST  = 8'h7A;
  localparam logic [BYTE_W-1:0] CASE_DELTA  = 8'h20;

  typedef enum logic [1:0] {
    ST_CAP_A = 2'd0,
    ST_CAP_B = 2'd1,
    ST_OUT_A = 2'd2,
    ST_OUT_B = 2'd3
  } puc_state_e;

endpackage

// File: rtl/puc_rst_sync.sv
module puc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/puc_case_xlate.sv
module puc_case_xlate #(
  parameter int unsigned     W     = 8,
  parameter logic [W-1:0]    LO    = 8'h61,
  parameter logic [W-1:0]    HI    = 8'h7A,
  parameter logic [W-1:0]    DELTA = 8'h20
) (
  input  logic [W-1:0] byte_in,
  output logic [W-1:0] byte_out
);

  logic in_range;

  always_comb begin
    in_range = (byte_in >= LO) && (byte_in <= HI);
    if (in_range) begin
      byte_out = byte_in - DELTA;
    end else begin
      byte_out = byte_in;
    end
  end

endmodule

// File: rtl/puc_slot_bank.sv
module puc_slot_bank #(
  parameter int unsigned W     = 8,
  parameter int unsigned SLOTS = 2,
  localparam int unsigned FLAT_W = W * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [SLOTS-1:0]  load_en,
  input  logic [FLAT_W-1:0] slot_d,
  output logic [FLAT_W-1:0] slot_q
);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [W-1:0] hold_q;
    logic [W-1:0] hold_d;
    logic         hold_ce;

    always_comb begin
      hold_ce = clr | load_en[g];
      if (clr) begin
        hold_d = '0;
      end else begin
        hold_d = slot_d[g*W +: W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
      end else if (hold_ce) begin
        hold_q <= hold_d;
      end
    end

    assign slot_q[g*W +: W] = hold_q;
  end

endmodule

// File: rtl/puc_pair_fsm.sv
module puc_pair_fsm
  import puc_pkg::*;
#(
  parameter int unsigned SLOTS = PAIR_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic             rd_en,
  output puc_state_e       state_q,
  output logic [SLOTS-1:0] load_en,
  output logic             full,
  output logic             empty,
  output logic             sel_second
);

  puc_state_e state_d;
  logic       state_ce;

  always_comb begin
    state_d = state_q;
    load_en = '0;
    if (clr) begin
      state_d = ST_CAP_A;
    end else begin
      unique case (state_q)
        ST_CAP_A: begin
          if (wr_en) begin
            load_en[0] = 1'b1;
            state_d    = ST_CAP_B;
          end
        end
        ST_CAP_B: begin
          if (wr_en) begin
            load_en[1] = 1'b1;
            state_d    = ST_OUT_A;
          end
        end
        ST_OUT_A: begin
          if (rd_en) state_d = ST_OUT_B;
        end
        ST_OUT_B: begin
          if (rd_en) state_d = ST_CAP_A;
        end
        default: state_d = ST_CAP_A;
      endcase
    end
    state_ce = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CAP_A;
    end else if (state_ce) begin
      state_q <= state_d;
    end
  end

  always_comb begin
    full       = (state_q == ST_OUT_A) || (state_q == ST_OUT_B);
    empty      = !full;
    sel_second = (state_q == ST_OUT_B);
  end

endmodule

// File: rtl/pair_upcase_stream.sv
module pair_upcase_stream
  import puc_pkg::*;
#(
  parameter int unsigned DATA_W     = BYTE_W,
  parameter int unsigned SYNC_DEPTH = 2,
  localparam int unsigned SLOTS     = PAIR_N,
  localparam int unsigned FLAT_W    = DATA_W * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_open,
  input  logic              rd_open,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);

  logic              rst_sync_n;
  logic              chan_clr;
  logic [SLOTS-1:0]  load_en;
  logic [DATA_W-1:0] first_up;
  logic [FLAT_W-1:0] slot_d;
  logic [FLAT_W-1:0] slot_q;
  logic              sel_second;
  puc_state_e        state_q;

  puc_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  assign chan_clr = !(wr_open || rd_open);

  puc_pair_fsm #(.SLOTS(SLOTS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (chan_clr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .state_q   (state_q),
    .load_en   (load_en),
    .full      (full),
    .empty     (empty),
    .sel_second(sel_second)
  );

  puc_case_xlate #(
    .W    (DATA_W),
    .LO   (DATA_W'(LOWER_FIRST)),
    .HI   (DATA_W'(LOWER_LAST)),
    .DELTA(DATA_W'(CASE_DELTA))
  ) u_xlate (
    .byte_in (wr_data),
    .byte_out(first_up)
  );

  assign slot_d = {wr_data, first_up};

  puc_slot_bank #(.W(DATA_W), .SLOTS(SLOTS)) u_slots (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (chan_clr),
    .load_en(load_en),
    .slot_d (slot_d),
    .slot_q (slot_q)
  );

  always_comb begin
    if (sel_second) begin
      rd_data = slot_q[DATA_W +: DATA_W];
    end else begin
      rd_data = slot_q[0 +: DATA_W];
    end
  end

endmodule

// File: rtl/puc_checker.sv
module puc_checker
  import puc_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic       wr_open,
  input logic       rd_open,
  input logic       wr_en,
  input logic       rd_en,
  input logic       full,
  input logic       empty,
  input logic [7:0] rd_data,
  input puc_state_e state_q
);

  logic open_any;
  assign open_any = wr_open || rd_open;

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (open_any && !empty && !rd_en) |=> (!empty && $stable(rd_data)));

  assert_full_blocks_write_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (open_any && full && wr_en && !rd_en) |=> (full && $stable(rd_data)));

  assert_close_clears_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!open_any) |=> (empty && !full));

  assert_first_then_second_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (open_any && state_q == ST_OUT_A && rd_en) |=> (state_q == ST_OUT_B && !empty));

  assert_pair_released_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (open_any && state_q == ST_OUT_B && rd_en) |=> (empty && !full));

  assert_first_upper_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_OUT_A) |-> !((rd_data >= 8'h61) && (rd_data <= 8'h7A)));

  assert_empty_read_noop_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (open_any && empty && !wr_en) |=> (empty && $stable(state_q)));

endmodule

bind pair_upcase_stream puc_checker u_puc_checker (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .wr_open   (wr_open),
  .rd_open   (rd_open),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .full      (full),
  .empty     (empty),
  .rd_data   (rd_data),
  .state_q   (state_q)
);

// File: tb/pair_upcase_stream_tb_top.sv
`timescale 1ns/1ps
module pair_upcase_stream_tb_top;

  logic       clk;
  logic       rst_n;
  logic       wr_open;
  logic       rd_open;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       full;
  logic       rd_en;
  logic [7:0] rd_data;
  logic       empty;

  int unsigned n_vec;
  int unsigned n_bad;
  bit          done;

  pair_upcase_stream dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_open(wr_open),
    .rd_open(rd_open),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .full   (full),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .empty  (empty)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] exp_first(input logic [7:0] b);
    if (b >= 8'h61 && b <= 8'h7A) return b - 8'h20;
    return b;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] b);
    wr_en   = 1'b1;
    wr_data = b;
    tick();
    wr_en   = 1'b0;
  endtask

  task automatic take(input string tag, input logic [7:0] exp, input bit junk_wr);
    check({tag, " empty"}, {7'd0, empty}, 8'd0);
    check(tag, rd_data, exp);
    rd_en = 1'b1;
    if (junk_wr) begin
      wr_en   = 1'b1;
      wr_data = 8'h5A;
    end
    tick();
    rd_en = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int unsigned n);
    for (int unsigned i = 0; i < n; i++) tick();
  endtask

  task automatic run_pair(input string tag, input logic [7:0] a, input logic [7:0] b);
    put(a);
    put(b);
    take({tag, " first"}, exp_first(a), 1'b0);
    take({tag, " second"}, b, 1'b0);
  endtask

  initial begin
    n_vec   = 0;
    n_bad   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    wr_open = 1'b1;
    rd_open = 1'b1;
    wr_en   = 1'b0;
    wr_data = 8'h00;
    rd_en   = 1'b0;
    void'($urandom(32'd715));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: idle state after reset
    check("R1 empty after reset", {7'd0, empty}, 8'd1);
    check("R1 full after reset", {7'd0, full}, 8'd0);

    // R2 R3 R4: "john" -> "JoHn"
    put("j");
    check("R1 one byte held empty", {7'd0, empty}, 8'd1);
    put("o");
    check("R4 full after pair", {7'd0, full}, 8'd1);
    take("R2 J", "J", 1'b0);
    take("R3 o", "o", 1'b0);
    check("R4 empty after pair", {7'd0, empty}, 8'd1);
    run_pair("R2 h/n", "h", "n");

    // R2: range edges, R3: second byte untouched even if lower case
    run_pair("R2 edge 60", 8'h60, 8'h61);
    run_pair("R2 edge 61", 8'h61, 8'h7A);
    run_pair("R2 edge 7A", 8'h7A, 8'h62);
    run_pair("R2 edge 7B", 8'h7B, 8'hE1);
    run_pair("R2 upper 41", 8'h41, 8'h00);
    run_pair("R2 high E1", 8'hE1, 8'hFF);

    // R5: writes while full ignored
    put("a");
    put("b");
    put(8'h33);
    put(8'h44);
    check("R5 data kept after refused writes", rd_data, "A");
    take("R5 first", "A", 1'b1);
    take("R5 second", "b", 1'b1);
    check("R5 no leaked byte", {7'd0, empty}, 8'd1);

    // R6: hold without read
    put("q");
    put("r");
    idle(5);
    check("R6 stable hold", rd_data, "Q");
    take("R6 first", "Q", 1'b0);
    idle(3);
    check("R6 stable second", rd_data, "r");
    take("R6 second", "r", 1'b0);

    // R7: read strobe while empty
    rd_en = 1'b1;
    tick();
    put("x");
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    put("y");
    take("R7 first survives", "X", 1'b0);
    take("R7 second", "y", 1'b0);

    // R8: close both channels mid pair
    put("k");
    wr_open = 1'b0;
    rd_open = 1'b0;
    tick();
    check("R8 cleared empty", {7'd0, empty}, 8'd1);
    wr_open = 1'b1;
    rd_open = 1'b1;
    put("m");
    check("R8 half pair discarded", {7'd0, empty}, 8'd1);
    put("z");
    take("R8 fresh first", "M", 1'b0);
    take("R8 fresh second", "z", 1'b0);

    // R9: one channel open is enough
    wr_open = 1'b0;
    run_pair("R9 rd only", "s", "t");
    wr_open = 1'b1;
    rd_open = 1'b0;
    run_pair("R9 wr only", "u", "v");
    rd_open = 1'b1;

    // Random pairs with gaps and handshake abuse
    for (int p = 0; p < 300; p++) begin
      logic [7:0] a;
      logic [7:0] b;
      a = 8'($urandom);
      b = 8'($urandom);
      if (($urandom % 4) == 0) begin
        rd_en = 1'b1;
      end
      put(a);
      rd_en = 1'b0;
      idle($urandom % 3);
      put(b);
      idle($urandom % 3);
      take("R2 random first", exp_first(a), 1'($urandom));
      idle($urandom % 2);
      take("R3 random second", b, 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule